// File: doc/BRIEF.md
# Gated 16-bit Compare Timer

This block is a single up-counting timer with four word-wide registers on a simple write strobe and combinational read port. Software picks what advances the counter: every bus clock, one step per 16 or per 256 bus clocks, or one step per rising edge of the horizontal-blank input. An optional gate, fed by either the horizontal or the vertical blank signal, either lets counting proceed only while the gate is low, or forces the counter back to zero on the chosen gate edge while counting carries on.

A compare register, a zero-return option and two sticky status flags (compare hit and wrap) drive a single interrupt line through per-flag enables. The flags share the mode register with the control bits and are cleared by writing ones to them. A one-cycle capture pulse copies the running count into a hold register, which can be left out by parameter.

The gate is decided by a four-state machine. GS_FREE: gate disabled, counting always allowed. GS_PASS: level gating with the gate input low, counting allowed. GS_BLOCK: level gating with the gate input high, counting stopped. GS_EDGE: an edge gate mode is selected, counting allowed and the counter cleared on each qualifying edge. Every cycle the next state is chosen from the mode: gate off goes to GS_FREE; level mode goes to GS_BLOCK when the synchronised gate is high and to GS_PASS when it is low; any edge mode goes to GS_EDGE.

Top module: `gate_cmp_timer`

## Requirements
- R1: After reset the count, mode, compare and hold registers read as zero and `irq` is low.
- R2: Byte offsets 0x00, 0x10, 0x20 and 0x30 (address bits [5:4]) select count, mode, compare and hold. Count, compare and hold occupy bits [15:0] with the upper bits reading zero. Mode bits [9:0] read back as written; bits 10 and 11 are the flags.
- R3: While mode bit 7 (run) is 0 the counter does not advance.
- R4: Mode bits [1:0] equal to 0, 1 and 2 advance the counter once per bus clock, once per 16 bus clocks and once per 256 bus clocks.
- R5: Mode bits [1:0] equal to 3 advance the counter once per rising edge of `hblank_in`, seen through a two-flop synchroniser.
- R6: With mode bit 2 set and bits [5:4] equal to 0, the counter advances only while the gate input is low; mode bit 3 picks the gate input, 0 for `hblank_in` and 1 for `vblank_in`.
- R7: With mode bit 2 set, bits [5:4] equal to 1, 2 or 3 clear the counter on a rising, falling or either edge of the gate input, and counting continues afterwards; other edges leave the count alone.
- R8: With mode bit 6 set, a step taken while the count equals the compare value returns the counter to zero.
- R9: Mode bit 10 is set by a step taken while the count equals the compare value; mode bit 11 is set by a step from 0xFFFF to 0.
- R10: Writing 1 to mode bit 10 or 11 clears that flag and writing 0 leaves it; a flag event in the same cycle as the clearing write wins.
- R11: `irq` is high exactly when (bit 10 and bit 8) or (bit 11 and bit 9) are set.
- R12: A bus write to the count register loads the counter directly and takes priority over stepping.
- R13: A one-cycle `capture_in` pulse copies the count into the hold register; with HAS_HOLD = 0 the hold register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| hblank_in | input | 1 | Horizontal blank, asynchronous |
| vblank_in | input | 1 | Vertical blank, asynchronous |
| capture_in | input | 1 | Synchronous capture event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two instances: one with every default (16-bit count, /16 and /256 prescale, hold register present) and one with HAS_HOLD set to 0, so both hold variants are read back after the same capture pulse. The default prescale ratios are small enough that whole periods of each fit in a few hundred cycles, so rates are checked as exact step counts over an integral number of periods whatever the prescaler phase. Because the count register can be loaded, the wrap from 0xFFFF and the compare-hit cycle are reached directly, including a clearing write that lands in the very cycle of a compare hit.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    typedef enum logic [1:0] {
        SRC_BUS   = 2'd0,
        SRC_DIV_A = 2'd1,
        SRC_DIV_B = 2'd2,
        SRC_HBL   = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        GM_LOW  = 2'd0,
        GM_RISE = 2'd1,
        GM_FALL = 2'd2,
        GM_BOTH = 2'd3
    } gate_mode_e;

    typedef enum logic [1:0] {
        GS_FREE,
        GS_PASS,
        GS_BLOCK,
        GS_EDGE
    } gate_state_e;

    // Control half of the mode register, bits [9:0], most significant first.
    typedef struct packed {
        logic       ov_ie;
        logic       eq_ie;
        logic       run;
        logic       zret;
        gate_mode_e gmode;
        logic       gsrc;
        logic       gate_en;
        clk_src_e   csel;
    } ctrl_t;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int B_EQ_FLG = 10;
    localparam int B_OV_FLG = 11;

    localparam logic [1:0] SEL_CNT  = 2'd0;
    localparam logic [1:0] SEL_MODE = 2'd1;
    localparam logic [1:0] SEL_CMP  = 2'd2;
    localparam logic [1:0] SEL_HOLD = 2'd3;

endpackage

// File: rtl/gtmr_sync_edge.sv
module gtmr_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic lvl,
    output logic rise,
    output logic fall
);
    // Two synchroniser flops plus one history flop for edge detection.
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], raw};
    end

    assign lvl  = sh_q[1];
    assign rise =  sh_q[1] & ~sh_q[2];
    assign fall = ~sh_q[1] &  sh_q[2];

    // R5
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R7
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/gtmr_prescale.sv
module gtmr_prescale #(
    parameter int A_LOG = 4,
    parameter int B_LOG = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_a,
    output logic tick_b
);
    localparam int PW = (B_LOG > A_LOG) ? B_LOG : A_LOG;

    logic [PW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + 1'b1;
    end

    assign tick_a = &pc_q[A_LOG-1:0];
    assign tick_b = &pc_q[B_LOG-1:0];

    // R4
    tick_a_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_a |=> !tick_a);
    // R4
    tick_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_b && B_LOG >= A_LOG) |-> tick_a);

endmodule

// File: rtl/gtmr_gate_fsm.sv
module gtmr_gate_fsm
    import gtmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_en,
    input  gate_mode_e gmode,
    input  logic       g_lvl,
    input  logic       g_rise,
    input  logic       g_fall,
    output logic       run_ok,
    output logic       zap
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!gate_en)             state_d = GS_FREE;
        else if (gmode == GM_LOW) state_d = g_lvl ? GS_BLOCK : GS_PASS;
        else                      state_d = GS_EDGE;
    end

    always_comb begin
        run_ok = 1'b1;
        zap    = 1'b0;
        unique case (state_q)
            GS_FREE:  run_ok = 1'b1;
            GS_PASS:  run_ok = 1'b1;
            GS_BLOCK: run_ok = 1'b0;
            GS_EDGE: begin
                unique case (gmode)
                    GM_RISE: zap = g_rise;
                    GM_FALL: zap = g_fall;
                    GM_BOTH: zap = g_rise | g_fall;
                    default: zap = 1'b0;
                endcase
            end
            default: run_ok = 1'b1;
        endcase
    end

    // R6
    gate_off_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> run_ok && !zap);
    // R7
    block_no_zap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |-> !zap);

endmodule

// File: rtl/gate_cmp_timer.sv
module gate_cmp_timer
    import gtmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6,
    parameter int PRE_A_LOG = 4,
    parameter int PRE_B_LOG = 8,
    parameter bit HAS_HOLD  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hblank_in,
    input  logic              vblank_in,
    input  logic              capture_in,
    output logic              irq
);
    localparam int N_BLANK = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Register select from byte offset bits [5:4].
    logic [1:0] sel;
    assign sel = bus_addr[5:4];

    logic wr_cnt, wr_mode, wr_cmp;
    assign wr_cnt  = bus_wr && (sel == SEL_CNT);
    assign wr_mode = bus_wr && (sel == SEL_MODE);
    assign wr_cmp  = bus_wr && (sel == SEL_CMP);

    logic unused_bits;
    assign unused_bits = ^{bus_addr[3:0], bus_wdata[DATA_W-1:B_OV_FLG+1]};

    // Blank input synchronisers, index 0 horizontal, 1 vertical.
    logic [N_BLANK-1:0] b_raw, b_lvl, b_rise, b_fall;
    assign b_raw = {vblank_in, hblank_in};

    for (genvar gi = 0; gi < N_BLANK; gi++) begin : g_sync
        gtmr_sync_edge u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (b_raw[gi]),
            .lvl  (b_lvl[gi]),
            .rise (b_rise[gi]),
            .fall (b_fall[gi])
        );
    end

    logic tick_a, tick_b;
    gtmr_prescale #(.A_LOG(PRE_A_LOG), .B_LOG(PRE_B_LOG)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_a(tick_a),
        .tick_b(tick_b)
    );

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q, cmp_q;
    logic             eq_q, ov_q;

    // Count source selection.
    logic tick;
    always_comb begin
        unique case (ctrl_q.csel)
            SRC_BUS:   tick = 1'b1;
            SRC_DIV_A: tick = tick_a;
            SRC_DIV_B: tick = tick_b;
            SRC_HBL:   tick = b_rise[0];
            default:   tick = 1'b0;
        endcase
    end

    // Gate input selection and gate state machine.
    logic g_lvl, g_rise, g_fall, run_ok, zap;
    assign g_lvl  = ctrl_q.gsrc ? b_lvl[1]  : b_lvl[0];
    assign g_rise = ctrl_q.gsrc ? b_rise[1] : b_rise[0];
    assign g_fall = ctrl_q.gsrc ? b_fall[1] : b_fall[0];

    gtmr_gate_fsm u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_en(ctrl_q.gate_en),
        .gmode  (ctrl_q.gmode),
        .g_lvl  (g_lvl),
        .g_rise (g_rise),
        .g_fall (g_fall),
        .run_ok (run_ok),
        .zap    (zap)
    );

    // Counter step and event detection.
    logic step, hit, live, eq_set, ov_set;
    assign step   = ctrl_q.run && tick && run_ok;
    assign hit    = (cnt_q == cmp_q);
    assign live   = step && !wr_cnt && !zap;
    assign eq_set = live && hit;
    assign ov_set = live && (cnt_q == CNT_MAX) && !(ctrl_q.zret && hit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= bus_wdata[CNT_W-1:0];
        end else if (zap) begin
            cnt_q <= '0;
        end else if (step) begin
            if (ctrl_q.zret && hit) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            eq_q   <= 1'b0;
            ov_q   <= 1'b0;
        end else begin
            if (wr_mode) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
            eq_q <= eq_set | (eq_q & ~(wr_mode & bus_wdata[B_EQ_FLG]));
            ov_q <= ov_set | (ov_q & ~(wr_mode & bus_wdata[B_OV_FLG]));
        end
    end

    // Hold register, present or tied off.
    logic [CNT_W-1:0] hold_rd;
    if (HAS_HOLD) begin : g_hold
        logic [CNT_W-1:0] hold_q;
        always_ff @(posedge clk) begin
            if (!rst_n)          hold_q <= '0;
            else if (capture_in) hold_q <= cnt_q;
        end
        assign hold_rd = hold_q;
    end else begin : g_nohold
        assign hold_rd = '0;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CNT:  bus_rdata[CNT_W-1:0] = cnt_q;
            SEL_MODE: begin
                bus_rdata[CTRL_W-1:0] = ctrl_q;
                bus_rdata[B_EQ_FLG]   = eq_q;
                bus_rdata[B_OV_FLG]   = ov_q;
            end
            SEL_CMP:  bus_rdata[CNT_W-1:0] = cmp_q;
            SEL_HOLD: bus_rdata[CNT_W-1:0] = hold_rd;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = (eq_q & ctrl_q.eq_ie) | (ov_q & ctrl_q.ov_ie);

    // R3
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_cnt && !zap) |=> $stable(cnt_q));
    // R8
    zret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && hit && ctrl_q.zret) |=> (cnt_q == '0) && eq_q);
    // R9
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cnt_q == CNT_MAX && !ctrl_q.zret) |=> (cnt_q == '0) && ov_q);
    // R10
    eq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_q && !(wr_mode && bus_wdata[B_EQ_FLG])) |=> eq_q);
    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.eq_ie && !ctrl_q.ov_ie) |-> !irq);
    // R12
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));

endmodule

// File: tb/tb_gate_cmp_timer.sv
module tb_gate_cmp_timer;

    localparam int A_CNT  = 'h00;
    localparam int A_MODE = 'h10;
    localparam int A_CMP  = 'h20;
    localparam int A_HOLD = 'h30;

    localparam logic [31:0] M_GEN  = 32'h004;
    localparam logic [31:0] M_GSRC = 32'h008;
    localparam logic [31:0] M_ZRET = 32'h040;
    localparam logic [31:0] M_RUN  = 32'h080;
    localparam logic [31:0] M_EQIE = 32'h100;
    localparam logic [31:0] M_OVIE = 32'h200;
    localparam logic [31:0] M_EQF  = 32'h400;
    localparam logic [31:0] M_OVF  = 32'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_nh;
    logic        hblank_in = 1'b0, vblank_in = 1'b0, capture_in = 1'b0;
    logic        irq, irq_nh;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gate_cmp_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hblank_in(hblank_in),
        .vblank_in(vblank_in), .capture_in(capture_in), .irq(irq)
    );

    gate_cmp_timer #(.HAS_HOLD(1'b0)) dut_nh (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_nh), .hblank_in(hblank_in),
        .vblank_in(vblank_in), .capture_in(capture_in), .irq(irq_nh)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_le(input string req, input logic [31:0] act, input logic [31:0] lim);
        checks++;
        if (act > lim) begin
            errors++;
            $display("FAIL %s actual %0d expected at most %0d", req, act, lim);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr[5:0]; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        bus_addr = addr[5:0];
        #1;
        data = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_MODE, v); check("R1 mode", v, 0);
        rd(A_CMP, v);  check("R1 compare", v, 0);
        rd(A_HOLD, v); check("R1 hold", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(A_CMP, 32'hFFFF_1234);
        rd(A_CMP, v);  check("R2 compare upper bits", v, 32'h0000_1234);
        wr(A_MODE, 32'hFFFF_F37F);
        rd(A_MODE, v); check("R2 mode readback", v, 32'h0000_037F);
        wr(A_MODE, M_EQF | M_OVF);
        wr(A_CNT, 32'h5555_ABCD);
        rd(A_CNT, v);  check("R12 count load", v, 32'h0000_ABCD);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        idle(20);
        rd(A_CNT, v); check("R3 no advance without run", v, 32'hABCD);
    endtask

    task automatic t_rates();
        logic [31:0] a, b;
        wr(A_MODE, M_RUN);
        wr(A_CNT, 100);
        rd(A_CNT, a); check("R12 load while running", a, 100);
        idle(7);
        rd(A_CNT, a); check("R4 bus clock rate", a, 107);
        wr(A_MODE, M_RUN | 32'd1);
        rd(A_CNT, a); idle(160); rd(A_CNT, b);
        check("R4 div16 rate", b - a, 10);
        wr(A_MODE, M_RUN | 32'd2);
        rd(A_CNT, a); idle(512); rd(A_CNT, b);
        check("R4 div256 rate", b - a, 2);
    endtask

    task automatic t_hblank_clk();
        logic [31:0] v;
        hblank_in = 1'b0;
        wr(A_MODE, M_RUN | 32'd3);
        idle(5);
        wr(A_CNT, 0);
        for (int i = 0; i < 5; i++) begin
            hblank_in = 1'b1; idle(4);
            hblank_in = 1'b0; idle(4);
        end
        idle(5);
        rd(A_CNT, v); check("R5 hblank edges", v, 5);
    endtask

    task automatic t_gate_level();
        logic [31:0] a, b;
        vblank_in = 1'b1;
        wr(A_MODE, M_RUN | M_GEN | M_GSRC);
        idle(5);
        rd(A_CNT, a);
        for (int i = 0; i < 3; i++) begin
            hblank_in = 1'b1; idle(2); hblank_in = 1'b0; idle(2);
        end
        rd(A_CNT, b); check("R6 blocked while vblank high", b, a);
        vblank_in = 1'b0;
        idle(5);
        rd(A_CNT, a); idle(10); rd(A_CNT, b);
        check("R6 counts while vblank low", b - a, 10);
    endtask

    task automatic t_gate_edge();
        logic [31:0] a, b;
        hblank_in = 1'b0;
        wr(A_MODE, M_RUN | M_GEN | (32'd1 << 4));
        wr(A_CNT, 1000);
        idle(5);
        hblank_in = 1'b1; idle(10);
        rd(A_CNT, a); check_le("R7 rising clears in mode 1", a, 10);
        hblank_in = 1'b0; idle(10);
        rd(A_CNT, b); check("R7 falling ignored in mode 1", b - a, 10);
        wr(A_MODE, M_RUN | M_GEN | (32'd2 << 4));
        idle(20);
        hblank_in = 1'b1; idle(10);
        rd(A_CNT, a); check_le("R7 rising ignored in mode 2", 40, a);
        hblank_in = 1'b0; idle(10);
        rd(A_CNT, a); check_le("R7 falling clears in mode 2", a, 10);
        wr(A_MODE, M_RUN | M_GEN | (32'd3 << 4));
        idle(20);
        hblank_in = 1'b1; idle(10);
        rd(A_CNT, a); check_le("R7 rising clears in mode 3", a, 10);
        idle(20);
        hblank_in = 1'b0; idle(10);
        rd(A_CNT, a); check_le("R7 falling clears in mode 3", a, 10);
    endtask

    task automatic t_compare();
        logic [31:0] v;
        wr(A_MODE, M_EQF | M_OVF);
        wr(A_CMP, 5);
        wr(A_MODE, M_RUN | M_ZRET | M_EQIE);
        wr(A_CNT, 0);
        idle(5);
        rd(A_CNT, v);  check("R8 reaches compare", v, 5);
        rd(A_MODE, v); check("R9 no eq flag before step", v & M_EQF, 0);
        idle(1);
        rd(A_CNT, v);  check("R8 zero return", v, 0);
        rd(A_MODE, v); check("R9 eq flag set", v & M_EQF, M_EQF);
        check("R11 irq on eq", {31'b0, irq}, 1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_MODE, M_EQIE);
        rd(A_MODE, v); check("R10 zero write keeps flag", v & M_EQF, M_EQF);
        wr(A_MODE, M_EQIE | M_EQF);
        rd(A_MODE, v); check("R10 one write clears flag", v & M_EQF, 0);
        check("R11 irq drops", {31'b0, irq}, 0);
        wr(A_MODE, M_RUN | M_ZRET | M_EQIE);
        wr(A_CNT, 3);
        idle(1);
        wr(A_MODE, M_RUN | M_ZRET | M_EQIE | M_EQF);
        rd(A_MODE, v); check("R10 set wins over clear", v & M_EQF, M_EQF);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(A_MODE, M_EQF | M_OVF);
        wr(A_MODE, M_RUN | M_OVIE);
        wr(A_CNT, 32'hFFFE);
        idle(1);
        rd(A_CNT, v); check("R9 at top", v, 32'hFFFF);
        check("R11 no irq before wrap", {31'b0, irq}, 0);
        idle(1);
        rd(A_CNT, v);  check("R9 wraps to zero", v, 0);
        rd(A_MODE, v); check("R9 overflow flag", v & M_OVF, M_OVF);
        check("R11 irq on wrap", {31'b0, irq}, 1);
        wr(A_MODE, 32'h0);
        check("R11 irq masked by enable", {31'b0, irq}, 0);
    endtask

    task automatic t_capture();
        logic [31:0] v;
        wr(A_MODE, M_RUN);
        wr(A_CNT, 200);
        idle(3);
        capture_in = 1'b1;
        @(negedge clk);
        capture_in = 1'b0;
        rd(A_HOLD, v); check("R13 hold captures count", v, 203);
        check("R13 hold absent reads zero", rdata_nh, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_regmap();
        t_idle();
        t_rates();
        t_hblank_clk();
        t_gate_level();
        t_gate_edge();
        t_compare();
        t_w1c();
        t_wrap();
        t_capture();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule